// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the six stored condition and control bits of an 8-bit accumulator CPU: carry, zero, interrupt mask, decimal, overflow and negative. Each cycle the instruction decoder gives it a per-flag update mask and a few source selects. The ALU gives it the side results of the current operation: add carry-out, subtract borrow, the bit shifted out, the accumulator sign bit, the operand and the 8-bit result. From these the block works out the new flag values. Flags outside the mask keep their values. The overflow bit is computed here from the operand, accumulator and result sign bits.

The block also formats the status byte that goes onto the stack, and it accepts a byte pulled back from the stack. The pushed byte carries two bits that have no storage. Bit 5 always reads as one. Bit 4 tells whether the push came from an instruction (a software push or a break) or from a hardware interrupt. When a byte is pulled, those two bits are dropped and the other six are loaded.

Top module: `cpu_status_reg`

## Requirements
- R1: While reset is asserted and after its release, the stored flags are `status_o = 6'b000100`. The index order is 0 C, 1 Z, 2 I, 3 D, 4 V, 5 N, so only the interrupt mask is set.
- R2: A flag whose `upd_en` bit is 0 keeps its value across the clock edge, unless `pull_en` is high.
- R3: When `upd_en[0]` is set, carry is loaded from a source chosen by `c_sel`: 0 gives `alu_carry`, 1 gives the inverse of `alu_borrow`, 2 gives `shift_bit`, 3 gives `const_val`.
- R4: When `nz_bit` is 0, an enabled Z is set exactly when `result` is zero, and an enabled N takes `result[7]`.
- R5: When `nz_bit` is 1 (bit test), an enabled N takes `opnd[7]` and Z still follows `result == 0`. With `v_sel` = 1, an enabled V takes `opnd[6]`.
- R6: With `v_sel` = 0, an enabled V flags signed overflow. For an add (`is_sub` = 0), overflow means both inputs have the same sign and the result sign differs. For a subtract, overflow means the input signs differ and the result sign differs from `acc_msb`.
- R7: With `v_sel` = 2, an enabled V clears to 0. With `v_sel` = 3, V holds even when enabled. No selection sets V to 1 without an operand.
- R8: Enabled I and D load `const_val`, which serves the set and clear commands.
- R9: When `pull_en` is high, the mask is ignored. The flags load from `pull_byte` bits 7, 6, 3, 2, 1, 0 into N, V, D, I, Z, C, and bits 5 and 4 are discarded.
- R10: `push_byte` is `{N, V, 1, push_sw, D, I, Z, C}` from bit 7 down to bit 0, taken from the stored flags without a clock delay.
- R11: A flag update takes effect at the first rising edge after the inputs are applied, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 6 | Per-flag update mask (0 C, 1 Z, 2 I, 3 D, 4 V, 5 N) |
| c_sel | input | 2 | Carry source select |
| v_sel | input | 2 | Overflow source select |
| nz_bit | input | 1 | N from operand bit 7 (bit test) instead of result |
| is_sub | input | 1 | Current arithmetic is a subtract or compare |
| const_val | input | 1 | Constant for set/clear commands |
| alu_carry | input | 1 | Add carry-out |
| alu_borrow | input | 1 | Subtract borrow-out |
| shift_bit | input | 1 | Bit shifted out by a shift or rotate |
| acc_msb | input | 1 | Accumulator bit 7 before the operation |
| opnd | input | 8 | ALU operand (memory value) |
| result | input | 8 | ALU result |
| pull_en | input | 1 | Load flags from the stack byte |
| pull_byte | input | 8 | Byte pulled from the stack |
| push_sw | input | 1 | Push cause: 1 instruction, 0 hardware interrupt |
| status_o | output | 6 | Stored flags |
| push_byte | output | 8 | Formatted status byte for the stack |

## Verification
Stored flags move exactly one rising edge after their inputs are applied, while the pushed byte follows the stored flags combinationally. The bench therefore drives inputs on the falling edge. It advances its model once, waits through the next rising edge and compares at the following falling edge. A probe taken before that rising edge shows that nothing has moved early. `push_byte` is compared in the same sampling slot against the model's flags, because it carries no register of its own.

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
  parameter logic [5:0] RST_FLAGS = 6'b000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] upd_en,
  input  logic [1:0] c_sel,
  input  logic [1:0] v_sel,
  input  logic       nz_bit,
  input  logic       is_sub,
  input  logic       const_val,
  input  logic       alu_carry,
  input  logic       alu_borrow,
  input  logic       shift_bit,
  input  logic       acc_msb,
  input  logic [7:0] opnd,
  input  logic [7:0] result,
  input  logic       pull_en,
  input  logic [7:0] pull_byte,
  input  logic       push_sw,
  output logic [5:0] status_o,
  output logic [7:0] push_byte
);
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FI = 2;
  localparam int FD = 3;
  localparam int FV = 4;
  localparam int FN = 5;

  logic [5:0] flags_q, flags_d, cand, pulled;
  logic       c_new, v_new, ovf, m_sign;

  always_comb begin
    unique case (c_sel)
      2'd0:    c_new = alu_carry;
      2'd1:    c_new = ~alu_borrow;
      2'd2:    c_new = shift_bit;
      default: c_new = const_val;
    endcase
  end

  assign m_sign = opnd[7] ^ is_sub;
  assign ovf    = (acc_msb == m_sign) && (result[7] != acc_msb);

  always_comb begin
    unique case (v_sel)
      2'd0:    v_new = ovf;
      2'd1:    v_new = opnd[6];
      2'd2:    v_new = 1'b0;
      default: v_new = flags_q[FV];
    endcase
  end

  assign cand[FC] = c_new;
  assign cand[FZ] = (result == 8'h00);
  assign cand[FI] = const_val;
  assign cand[FD] = const_val;
  assign cand[FV] = v_new;
  assign cand[FN] = nz_bit ? opnd[7] : result[7];

  assign pulled  = {pull_byte[7], pull_byte[6], pull_byte[3:0]};
  assign flags_d = pull_en ? pulled : ((upd_en & cand) | (~upd_en & flags_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= RST_FLAGS;
    else        flags_q <= flags_d;
  end

  assign status_o  = flags_q;
  assign push_byte = {flags_q[FN], flags_q[FV], 1'b1, push_sw,
                      flags_q[FD], flags_q[FI], flags_q[FZ], flags_q[FC]};
endmodule

module cpu_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] upd_en,
  input logic [1:0] v_sel,
  input logic       is_sub,
  input logic       acc_msb,
  input logic [7:0] opnd,
  input logic [7:0] result,
  input logic       pull_en,
  input logic [7:0] pull_byte,
  input logic       push_sw,
  input logic [5:0] status_o,
  input logic [7:0] push_byte
);
  // R2
  hold_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull_en && upd_en == 6'b0) |=> $stable(status_o));

  // R9
  pull_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en |=> status_o == {$past(pull_byte[7:6]), $past(pull_byte[3:0])});

  // R7
  v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull_en && upd_en[4] && v_sel == 2'd2) |=> !status_o[4]);

  // R6
  add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull_en && upd_en[4] && v_sel == 2'd0 && !is_sub &&
     !acc_msb && !opnd[7] && result[7]) |=> status_o[4]);

  // R10
  push_fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_byte[5] && (push_byte[4] == push_sw));

  // R10
  push_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {push_byte[7:6], push_byte[3:0]} == status_o);
endmodule

bind cpu_status_reg cpu_status_reg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .v_sel(v_sel), .is_sub(is_sub),
  .acc_msb(acc_msb), .opnd(opnd), .result(result), .pull_en(pull_en),
  .pull_byte(pull_byte), .push_sw(push_sw), .status_o(status_o),
  .push_byte(push_byte)
);

// File: tb/cpu_status_reg_tb.sv
module cpu_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] upd_en = '0;
  logic [1:0] c_sel = '0, v_sel = '0;
  logic       nz_bit = 0, is_sub = 0, const_val = 0, alu_carry = 0;
  logic       alu_borrow = 0, shift_bit = 0, acc_msb = 0, pull_en = 0, push_sw = 0;
  logic [7:0] opnd = '0, result = '0, pull_byte = '0;
  logic [5:0] status_o;
  logic [7:0] push_byte;
  logic [5:0] exp_f;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cpu_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .c_sel(c_sel), .v_sel(v_sel),
    .nz_bit(nz_bit), .is_sub(is_sub), .const_val(const_val), .alu_carry(alu_carry),
    .alu_borrow(alu_borrow), .shift_bit(shift_bit), .acc_msb(acc_msb), .opnd(opnd),
    .result(result), .pull_en(pull_en), .pull_byte(pull_byte), .push_sw(push_sw),
    .status_o(status_o), .push_byte(push_byte)
  );

  function automatic logic [5:0] model(logic [5:0] f);
    logic [5:0] n = f;
    logic a = acc_msb, m = opnd[7], r = result[7];
    if (pull_en) return {pull_byte[7:6], pull_byte[3:0]};
    if (upd_en[0])
      case (c_sel)
        2'd0: n[0] = alu_carry;
        2'd1: n[0] = !alu_borrow;
        2'd2: n[0] = shift_bit;
        default: n[0] = const_val;
      endcase
    if (upd_en[1]) n[1] = (result == 8'h00);
    if (upd_en[2]) n[2] = const_val;
    if (upd_en[3]) n[3] = const_val;
    if (upd_en[4])
      case (v_sel)
        2'd0: n[4] = is_sub ? ((a & !m & !r) | (!a & m & r))
                            : ((a & m & !r) | (!a & !m & r));
        2'd1: n[4] = opnd[6];
        2'd2: n[4] = 1'b0;
        default: ;
      endcase
    if (upd_en[5]) n[5] = nz_bit ? opnd[7] : result[7];
    return n;
  endfunction

  function automatic logic [7:0] fmt(logic [5:0] f, logic sw);
    return {f[5], f[4], 1'b1, sw, f[3:0]};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    upd_en = '0; c_sel = '0; v_sel = '0; nz_bit = 0; is_sub = 0; const_val = 0;
    alu_carry = 0; alu_borrow = 0; shift_bit = 0; acc_msb = 0; opnd = '0;
    result = '0; pull_en = 0; pull_byte = '0;
  endtask

  task automatic step(string req);
    exp_f = model(exp_f);
    @(posedge clk);
    @(negedge clk);
    check(req, {2'b0, status_o}, {2'b0, exp_f});
    check(req, push_byte, fmt(exp_f, push_sw));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_f = 6'b000100;
    repeat (3) @(negedge clk);
    check("R1 reset flags", {2'b0, status_o}, 8'h04);
    check("R10 reset push", push_byte, 8'h24);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {2'b0, status_o}, 8'h04);

    idle(); upd_en = 6'b000001; c_sel = 2'd0; alu_carry = 1; step("R3 add carry");
    idle(); upd_en = 6'b000001; c_sel = 2'd1; alu_borrow = 1; step("R3 sub borrow");
    idle(); upd_en = 6'b000001; c_sel = 2'd2; shift_bit = 1; step("R3 shift bit");
    idle(); upd_en = 6'b000001; c_sel = 2'd3; const_val = 0; step("R3 const clear");
    idle(); upd_en = 6'b100010; result = 8'h00; step("R4 zero result");
    idle(); upd_en = 6'b100010; result = 8'h80; step("R4 negative result");
    idle(); upd_en = 6'b110010; nz_bit = 1; v_sel = 2'd1; opnd = 8'hC0; result = 8'h00;
    step("R5 bit test");
    idle(); upd_en = 6'b010000; acc_msb = 0; opnd = 8'h50; result = 8'hA0; step("R6 add ovf");
    idle(); upd_en = 6'b010000; acc_msb = 0; opnd = 8'h10; result = 8'h60; step("R6 add no ovf");
    idle(); upd_en = 6'b010000; is_sub = 1; acc_msb = 0; opnd = 8'hB0; result = 8'hA0;
    step("R6 sub ovf");
    idle(); upd_en = 6'b010000; v_sel = 2'd3; step("R7 hold select");
    idle(); upd_en = 6'b010000; v_sel = 2'd2; opnd = 8'hFF; step("R7 clear");
    idle(); upd_en = 6'b001100; const_val = 1; step("R8 set I D");
    idle(); upd_en = 6'b001100; const_val = 0; step("R8 clear I D");
    idle(); upd_en = 6'b000000; c_sel = 2'd3; const_val = 1; result = 8'h80; opnd = 8'hFF;
    step("R2 masked off");
    idle(); pull_en = 1; pull_byte = 8'h30; upd_en = 6'b111111; const_val = 1; step("R9 pull drops 5 4");
    idle(); pull_en = 1; pull_byte = 8'hCF; step("R9 pull all");
    idle(); push_sw = 1; #1;
    check("R10 push by instruction", push_byte, 8'hFF);
    push_sw = 0; #1;
    check("R10 push by interrupt", push_byte, 8'hEF);
    idle(); upd_en = 6'b111111; #2;
    check("R11 no early change", {2'b0, status_o}, {2'b0, exp_f});
    step("R11 update at edge");

    for (int k = 0; k < 3000; k++) begin
      upd_en = 6'($urandom); c_sel = 2'($urandom); v_sel = 2'($urandom);
      nz_bit = 1'($urandom); is_sub = 1'($urandom); const_val = 1'($urandom);
      alu_carry = 1'($urandom); alu_borrow = 1'($urandom); shift_bit = 1'($urandom);
      acc_msb = 1'($urandom); opnd = 8'($urandom);
      result = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
      pull_en = ($urandom % 8 == 0); pull_byte = 8'($urandom); push_sw = 1'($urandom);
      step("random mix");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule